// File: doc/BRIEF.md
# Dual External Interrupt Request Latch

This block turns two asynchronous, active-low interrupt pins into two request lines for an interrupt controller. Each channel has a trigger-type bit. With the bit set, a falling edge on the pin latches the channel's request flag. The flag then stays set until the interrupt is serviced or software clears it. With the bit clear, the flag follows the pin level: it is set while the pin is low and clear while it is high.

A small 4-bit register holds both type bits and both request flags. Software writes the type bits and can clear a flag by writing zero to its position. The interrupt controller pulses a per-channel acknowledge when it services a request, and in edge mode this clears the flag. Each pin passes through a two-flop synchronizer, so a pin change reaches the request output on the third rising clock edge.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, both type bits and both request flags are 0, so `reg_rdata` reads 4'b0000 and `irq_req` is 2'b00 while both pins are high.
- R2: The register layout is: bit 3 is the channel-1 flag, bit 2 the channel-1 type, bit 1 the channel-0 flag and bit 0 the channel-0 type. A write loads bits 2 and 0 into the type bits.
- R3: In level mode (type 0), the flag becomes 1 on the third rising edge after the pin goes low, and becomes 0 on the third rising edge after the pin goes high.
- R4: In edge mode (type 1), a falling edge on the pin sets the flag on the third rising edge after the fall. The flag stays set after the pin returns high, and a pin held low sets it only once.
- R5: In edge mode, an acknowledge pulse for a channel clears that channel's flag on the next rising edge.
- R6: In edge mode, a register write with a 0 in a flag bit clears that flag on the next rising edge. A write with a 1 in a flag bit leaves that flag unchanged and never sets it.
- R7: In level mode, an acknowledge or a software clear does not hold the flag clear: while the synchronized pin stays low, the flag is 1 on the next cycle.
- R8: In edge mode, if a new falling edge is detected in the same cycle as an acknowledge or a software clear, the flag remains set.
- R9: The two channels are independent. A pin, acknowledge or type change on one channel never alters the other channel's flag.
- R10: `irq_req[1]` equals register bit 3 and `irq_req[0]` equals register bit 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 2 | Asynchronous active-low interrupt pins, index = channel |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register contents {flag1, type1, flag0, type0} |
| irq_ack | input | 2 | Service-acknowledge pulse per channel |
| irq_req | output | 2 | Request output per channel |

## Verification
In level mode, the bench drives a low pulse and then a release, and checks that the flag tracks the pin. In edge mode, it drives a fall followed by a release, and a pin held low across an acknowledge. These show that edge latching differs from level following and that a held-low pin does not retrigger. Acknowledges and software writes are applied both alone and in the exact cycle a new edge is detected; this separates a clear that loses an event from one that keeps it. Stimulus on one channel while the other is idle or in the other mode exposes any crosstalk between channels.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] irq_pin_n,
  input  logic       reg_wr,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic [1:0] irq_ack,
  output logic [1:0] irq_req
);

  logic [1:0] s1, s2, s2_d;
  logic [1:0] typ, flag;
  logic [1:0] fall, swclr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= 2'b11;
      s2   <= 2'b11;
      s2_d <= 2'b11;
    end else begin
      s1   <= irq_pin_n;
      s2   <= s1;
      s2_d <= s2;
    end

  assign fall  = s2_d & ~s2;
  assign swclr = {reg_wr & ~reg_wdata[3], reg_wr & ~reg_wdata[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      typ <= 2'b00;
    else if (reg_wr)
      typ <= {reg_wdata[2], reg_wdata[0]};

  for (genvar i = 0; i < 2; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        flag[i] <= 1'b0;
      else if (typ[i])
        flag[i] <= fall[i] | (flag[i] & ~irq_ack[i] & ~swclr[i]);
      else
        flag[i] <= ~s2[i];
  end

  assign irq_req   = flag;
  assign reg_rdata = {flag[1], typ[1], flag[0], typ[0]};

endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] typ,
  input logic [1:0] s2,
  input logic [1:0] s2_d,
  input logic [1:0] irq_req,
  input logic [1:0] irq_ack,
  input logic       reg_wr,
  input logic [3:0] reg_wdata,
  input logic [3:0] reg_rdata
);

  // R10
  always_comb if (rst_n) req_map_chk: assert (irq_req == {reg_rdata[3], reg_rdata[1]});

  for (genvar i = 0; i < 2; i++) begin : g_c
    // R4
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (typ[i] && s2_d[i] && !s2[i]) |=> irq_req[i]);
    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !typ[i] |=> (irq_req[i] == !$past(s2[i])));
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (typ[i] && irq_ack[i] && !(s2_d[i] && !s2[i])) |=> !irq_req[i]);
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (typ[i] && irq_req[i] && !irq_ack[i] && !(reg_wr && !reg_wdata[2*i+1])) |=> irq_req[i]);
    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (typ[i] && !irq_req[i] && !(s2_d[i] && !s2[i])) |=> !irq_req[i]);
  end

endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .typ(typ), .s2(s2), .s2_d(s2_d),
  .irq_req(irq_req), .irq_ack(irq_ack), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/tb_ext_irq_latch.sv
module tb_ext_irq_latch;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] irq_pin_n = 2'b11;
  logic       reg_wr = 0;
  logic [3:0] reg_wdata = 0;
  logic [3:0] reg_rdata;
  logic [1:0] irq_ack = 0;
  logic [1:0] irq_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_latch dut (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    reg_wr = 1; reg_wdata = d;
    step(1);
    reg_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1", reg_rdata, 4'b0000);
    chk("R1", {2'b00, irq_req}, 4'b0000);
  endtask

  task automatic t_layout;
    wr(4'b1101);
    chk("R2", reg_rdata, 4'b0101);
    wr(4'b1000);
    chk("R2", reg_rdata, 4'b0000);
  endtask

  task automatic t_level;
    irq_pin_n[0] = 0;
    step(2);
    chk("R3", {3'b0, irq_req[0]}, 4'd0);
    step(1);
    chk("R3", reg_rdata, 4'b0010);
    // R9 channel 1 untouched
    chk("R9", {3'b0, irq_req[1]}, 4'd0);
    irq_ack[0] = 1;
    step(1);
    irq_ack[0] = 0;
    chk("R7", {3'b0, irq_req[0]}, 4'd1);
    wr(4'b0000);
    chk("R7", reg_rdata, 4'b0010);
    irq_pin_n[0] = 1;
    step(2);
    chk("R3", {3'b0, irq_req[0]}, 4'd1);
    step(1);
    chk("R3", reg_rdata, 4'b0000);
  endtask

  task automatic t_edge;
    wr(4'b1111);
    chk("R2", reg_rdata, 4'b0101);
    irq_pin_n[1] = 0;
    step(2);
    chk("R4", {2'b0, irq_req}, 4'b00);
    step(1);
    chk("R4", reg_rdata, 4'b1101);
    chk("R10", {2'b0, irq_req}, 4'b10);
    irq_pin_n[1] = 1;
    step(4);
    chk("R4", {3'b0, irq_req[1]}, 4'd1);
    irq_ack[1] = 1;
    step(1);
    irq_ack[1] = 0;
    chk("R5", {2'b0, irq_req}, 4'b00);
    // held low: only one set
    irq_pin_n[0] = 0;
    step(3);
    chk("R4", {2'b0, irq_req}, 4'b01);
    irq_ack[0] = 1;
    step(1);
    irq_ack[0] = 0;
    step(4);
    chk("R4", {2'b0, irq_req}, 4'b00);
    irq_pin_n[0] = 1;
    step(3);
  endtask

  task automatic t_swclr;
    irq_pin_n = 2'b00;
    step(3);
    chk("R4", {2'b0, irq_req}, 4'b11);
    irq_pin_n = 2'b11;
    step(3);
    wr(4'b1111);
    chk("R6", reg_rdata, 4'b1111);
    wr(4'b0111);
    chk("R6", reg_rdata, 4'b0111);
    chk("R9", {3'b0, irq_req[0]}, 4'd1);
    wr(4'b0101);
    chk("R6", reg_rdata, 4'b0101);
  endtask

  task automatic t_race;
    // make flag set, then new edge coincides with ack / software clear
    irq_pin_n[0] = 0;
    step(3);
    irq_pin_n[0] = 1;
    step(3);
    chk("R4", {3'b0, irq_req[0]}, 4'd1);
    irq_pin_n[0] = 0;
    step(2);
    irq_ack[0] = 1;
    step(1);
    irq_ack[0] = 0;
    chk("R8", {3'b0, irq_req[0]}, 4'd1);
    irq_pin_n[0] = 1;
    step(3);
    irq_pin_n[0] = 0;
    step(2);
    reg_wr = 1; reg_wdata = 4'b0101;
    step(1);
    reg_wr = 0;
    chk("R8", reg_rdata, 4'b0111);
    irq_ack[0] = 1;
    step(1);
    irq_ack[0] = 0;
    chk("R5", reg_rdata, 4'b0101);
    irq_pin_n[0] = 1;
    step(3);
  endtask

  task automatic t_mixed;
    wr(4'b0100);
    irq_pin_n = 2'b00;
    step(3);
    chk("R9", reg_rdata, 4'b1110);
    irq_pin_n = 2'b11;
    step(3);
    chk("R9", reg_rdata, 4'b1100);
    irq_ack[1] = 1;
    step(1);
    irq_ack[1] = 0;
    chk("R9", reg_rdata, 4'b0100);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_layout();
    t_level();
    t_edge();
    t_swclr();
    t_race();
    t_mixed();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule